// File: doc/BRIEF.md
# Pattern-Triggered Spatial Capture Unit

This block is a passive debug recorder that sits beside a calorimeter cluster trigger. On every cycle the trigger path presents a sample: one hit bit and one cluster-found bit for each crystal in a ROWS x COLS array. The block only listens to this stream. It has no ready signal and cannot stall or alter the stream. While armed, it writes each valid sample into a circular history buffer. It fires on a programmable condition built from two parts: a three-state per-crystal picture (must be hit, must be quiet, or ignored) and a minimum number of cluster-found flags. A mode field selects which parts are used and how they combine.

When the block fires, it keeps recording until a fixed number of post-trigger samples has been stored. It then freezes the buffer and holds the buffer address of the trigger sample. Software reads back through a valid/ready request channel. Each request carries a signed offset relative to the trigger sample, so the reader can step backwards and forwards in time. Each result returns on a valid/ready response channel. A new request is accepted only when the response slot is empty or is being drained in the same cycle. A response stays unchanged for as long as `rsp_ready` is low. A pulse on `arm` starts a new capture.

Top module: `sla_spatial_scope`

## Requirements
- R1: After reset the three status outputs are low, `req_ready` is low and `rsp_valid` is low.
- R2: The pattern part matches when, for every crystal i with `cfg_care[i]`=1, `in_hit[i]` equals `cfg_value[i]`. Crystals with `cfg_care[i]`=0 are ignored.
- R3: The count part holds when the number of set bits in `in_clus` is at least `cfg_min_clusters`.
- R4: `cfg_mode` selects the firing rule: 2'b00 uses the pattern only, 2'b01 uses the count only, 2'b10 requires both, and 2'b11 accepts either.
- R5: A sample is recorded only in a cycle where `in_valid` is high and the block is armed or collecting post-trigger data. Cycles with `in_valid` low leave no trace in the capture.
- R6: After `arm`, a matching sample is ignored until PRE valid samples have been recorded. The first match after that becomes the trigger sample.
- R7: At most one of `st_armed`, `st_triggered` and `st_done` is high. After the trigger sample, exactly POST further valid samples are recorded in state triggered, and the last one moves the block to done.
- R8: A read request with offset o in [-PRE, POST] returns the sample recorded o valid samples after the trigger sample, with `rsp_inwin`=1. Offset 0 returns the trigger sample itself.
- R9: A read request with an offset outside [-PRE, POST] returns `rsp_inwin`=0 with all-zero hit and cluster data.
- R10: `req_ready` is high only in the done state, one request is taken per handshake, and its response is valid in the following cycle.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response data stays unchanged and `req_ready` is low.
- R12: A pulse on `arm` restarts capture from any state. The block moves to armed, which clears done and blocks reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Monitored sample is valid this cycle |
| in_hit | input | ROWS*COLS | Per-crystal hit bits, index r*COLS+c |
| in_clus | input | ROWS*COLS | Per-crystal cluster-found bits |
| cfg_care | input | ROWS*COLS | 1 = crystal takes part in the pattern |
| cfg_value | input | ROWS*COLS | Required hit state for cared crystals |
| cfg_min_clusters | input | $clog2(ROWS*COLS+1) | Minimum cluster-flag count |
| cfg_mode | input | 2 | Firing rule select (see R4) |
| arm | input | 1 | Start a new capture |
| st_armed | output | 1 | Recording, waiting for a trigger |
| st_triggered | output | 1 | Recording post-trigger samples |
| st_done | output | 1 | Capture frozen, readable |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_offset | input | $clog2(PRE+POST+1)+1 | Signed offset from the trigger sample |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_inwin | output | 1 | Offset was inside the captured window |
| rsp_hit | output | ROWS*COLS | Captured hit bits |
| rsp_clus | output | ROWS*COLS | Captured cluster-found bits |

## Verification
Some faults are invisible in the status flags. If the write pointer or the latched trigger address is wrong, the flags still look correct, and the fault shows up only at readout. Offset 0 then returns a non-matching picture, or the ends of the window return neighbouring samples, so the reads at -PRE, -1, 0, +1 and +POST catch it on the first capture. A wrong fill or post counter shows up within one sample: an early match sets `st_triggered`, or `st_done` rises one sample early or late. Since the bench drives the inputs, it knows exactly which sample that is. A broken response register shows up when data changes while `rsp_ready` is held low.

// File: rtl/sla_pkg.sv
package sla_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  typedef enum logic [1:0] {
    MODE_PAT = 2'b00,
    MODE_CNT = 2'b01,
    MODE_AND = 2'b10,
    MODE_OR  = 2'b11
  } trig_mode_e;

endpackage

// File: rtl/sla_trig_match.sv
module sla_trig_match
  import sla_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int N  = ROWS * COLS,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  hit,
  input  logic [N-1:0]  clus,
  input  logic [N-1:0]  care,
  input  logic [N-1:0]  value,
  input  logic [CW-1:0] min_cl,
  input  logic [1:0]    mode,
  output logic          fire
);

  logic [ROWS-1:0] row_ok;
  logic            pat_ok;
  logic            cnt_ok;
  logic [CW-1:0]   cnt;

  // per-row pattern compare: a cared pixel must equal its value
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] h_r, v_r, c_r;
    assign h_r = hit[r*COLS +: COLS];
    assign v_r = value[r*COLS +: COLS];
    assign c_r = care[r*COLS +: COLS];
    assign row_ok[r] = &(~c_r | ~(h_r ^ v_r));
  end

  assign pat_ok = &row_ok;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(clus[i]);
  end

  assign cnt_ok = (cnt >= min_cl);

  always_comb begin
    unique case (trig_mode_e'(mode))
      MODE_PAT: fire = pat_ok;
      MODE_CNT: fire = cnt_ok;
      MODE_AND: fire = pat_ok & cnt_ok;
      MODE_OR:  fire = pat_ok | cnt_ok;
      default:  fire = 1'b0;
    endcase
  end

  // R4: in AND mode a fire must have both parts true
  always_comb begin
    if (trig_mode_e'(mode) == MODE_AND && fire)
      p_and_needs_both_r4: assert (pat_ok && cnt_ok);
  end

endmodule

// File: rtl/sla_capture_ctrl.sv
module sla_capture_ctrl
  import sla_pkg::*;
#(
  parameter int PRE  = 63,
  parameter int POST = 64,
  localparam int AW = $clog2(PRE + POST + 1),
  localparam int FW = $clog2(PRE + 1),
  localparam int PW = $clog2(POST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          in_valid,
  input  logic          fire,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] trig_addr,
  output cap_state_e    state
);

  logic [FW-1:0] fill;
  logic [PW-1:0] post_cnt;
  logic          fill_full;
  logic          take_trig;
  logic          post_last;

  assign fill_full = (fill == FW'(PRE));
  assign wr_en     = in_valid && (state == ST_ARMED || state == ST_POST);
  assign take_trig = in_valid && state == ST_ARMED && fill_full && fire;
  assign post_last = (post_cnt == PW'(POST - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_addr   <= '0;
      trig_addr <= '0;
      fill      <= '0;
      post_cnt  <= '0;
    end else begin
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (arm) begin
        state    <= ST_ARMED;
        fill     <= '0;
        post_cnt <= '0;
      end else begin
        unique case (state)
          ST_ARMED: begin
            if (in_valid && !fill_full) fill <= fill + 1'b1;
            if (take_trig) begin
              state     <= ST_POST;
              trig_addr <= wr_addr;
              post_cnt  <= '0;
            end
          end
          ST_POST: begin
            if (in_valid) begin
              post_cnt <= post_cnt + 1'b1;
              if (post_last) state <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: no trigger is taken before the pre-trigger history is full
  p_fill_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !arm && !fill_full) |=> state != ST_POST);

  // R7: a frozen capture neither writes nor moves its trigger address
  p_done_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !arm) |=> (state == ST_DONE && $stable(wr_addr)
                                    && $stable(trig_addr)));

  // R12: arm always lands in the armed state
  p_arm_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> state == ST_ARMED);

endmodule

// File: rtl/sla_hist_ram.sv
module sla_hist_ram #(
  parameter int W  = 32,
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/sla_spatial_scope.sv
module sla_spatial_scope
  import sla_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int PRE  = 63,
  parameter int POST = 64,
  localparam int N  = ROWS * COLS,
  localparam int CW = $clog2(N + 1),
  localparam int AW = $clog2(PRE + POST + 1),
  localparam int OW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N-1:0]  in_hit,
  input  logic [N-1:0]  in_clus,
  input  logic [N-1:0]  cfg_care,
  input  logic [N-1:0]  cfg_value,
  input  logic [CW-1:0] cfg_min_clusters,
  input  logic [1:0]    cfg_mode,
  input  logic          arm,
  output logic          st_armed,
  output logic          st_triggered,
  output logic          st_done,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [OW-1:0] req_offset,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_inwin,
  output logic [N-1:0]  rsp_hit,
  output logic [N-1:0]  rsp_clus
);

  logic          fire;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] trig_addr;
  cap_state_e    state;
  logic [2*N-1:0] rd_word;
  logic          req_acc;
  logic          off_inwin;
  logic [AW-1:0] rd_addr;
  logic signed [OW-1:0] off_s;
  logic          rsp_v_q;
  logic          inwin_q;

  sla_trig_match #(.ROWS(ROWS), .COLS(COLS)) u_match (
    .hit(in_hit), .clus(in_clus), .care(cfg_care), .value(cfg_value),
    .min_cl(cfg_min_clusters), .mode(cfg_mode), .fire(fire)
  );

  sla_capture_ctrl #(.PRE(PRE), .POST(POST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(in_valid), .fire(fire),
    .wr_en(wr_en), .wr_addr(wr_addr), .trig_addr(trig_addr), .state(state)
  );

  sla_hist_ram #(.W(2*N), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({in_hit, in_clus}),
    .re(req_acc), .raddr(rd_addr), .rdata(rd_word)
  );

  assign st_armed     = (state == ST_ARMED);
  assign st_triggered = (state == ST_POST);
  assign st_done      = (state == ST_DONE);

  // readout: one response slot, refilled when empty or draining
  assign req_ready = st_done && (!rsp_v_q || rsp_ready);
  assign req_acc   = req_valid && req_ready;
  assign off_s     = $signed(req_offset);
  assign off_inwin = (int'(off_s) >= -PRE) && (int'(off_s) <= POST);
  assign rd_addr   = trig_addr + req_offset[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      inwin_q <= 1'b0;
    end else if (req_acc) begin
      rsp_v_q <= 1'b1;
      inwin_q <= off_inwin;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_inwin = inwin_q;
  assign rsp_hit   = inwin_q ? rd_word[2*N-1:N] : '0;
  assign rsp_clus  = inwin_q ? rd_word[N-1:0]   : '0;

  // R7: status flags are mutually exclusive
  p_status_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_armed, st_triggered, st_done}));

  // R10: reads are offered only on a frozen capture
  p_read_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> st_done);

  // R11: a stalled response holds still
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                   && $stable(rsp_clus) && $stable(rsp_inwin)));

  // R9: out-of-window responses carry no data
  p_zero_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_inwin) |-> (rsp_hit == '0 && rsp_clus == '0));

endmodule

// File: tb/test_sla_spatial_scope.sv
module test_sla_spatial_scope;

  localparam int ROWS = 4, COLS = 4, PRE = 63, POST = 64;
  localparam int N = ROWS * COLS;
  localparam int CW = $clog2(N + 1);
  localparam int OW = $clog2(PRE + POST + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_hit = '0, in_clus = '0, cfg_care = '0, cfg_value = '0;
  logic [CW-1:0] cfg_min_clusters = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic arm = 1'b0;
  logic st_armed, st_triggered, st_done;
  logic req_valid = 1'b0, req_ready;
  logic [OW-1:0] req_offset = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_inwin;
  logic [N-1:0] rsp_hit, rsp_clus;

  int total = 0, bad = 0;
  logic [N-1:0] lh [0:1023];
  logic [N-1:0] lcl [0:1023];
  int lc = 0;

  always #10 clk = ~clk;

  sla_spatial_scope #(.ROWS(ROWS), .COLS(COLS), .PRE(PRE), .POST(POST)) i_sla_spatial_scope (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hit(in_hit), .in_clus(in_clus),
    .cfg_care(cfg_care), .cfg_value(cfg_value), .cfg_min_clusters(cfg_min_clusters),
    .cfg_mode(cfg_mode), .arm(arm), .st_armed(st_armed), .st_triggered(st_triggered),
    .st_done(st_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_inwin(rsp_inwin), .rsp_hit(rsp_hit), .rsp_clus(rsp_clus)
  );

  task automatic chk(input logic ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    lc = 0;
  endtask

  // one valid sample, logged as the bench expects it to be stored
  task automatic send(input logic [N-1:0] h, input logic [N-1:0] c);
    in_valid = 1'b1; in_hit = h; in_clus = c;
    lh[lc] = h; lcl[lc] = c; lc++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // invalid cycle with junk data: must not be recorded (R5)
  task automatic gap();
    in_valid = 1'b0; in_hit = 16'h5A5A; in_clus = 16'hFFFF;
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] bgh(input int k);
    return N'(k * 40503) | 16'h000F;
  endfunction

  task automatic send_bg(input int n, input logic [N-1:0] c);
    for (int i = 0; i < n; i++) begin
      send(bgh(lc), c);
      if (lc % 7 == 0) gap();
    end
  endtask

  task automatic rd(input int o, input int t, input string tag);
    logic ein;
    logic [N-1:0] eh, ec;
    ein = (o >= -PRE) && (o <= POST);
    eh = ein ? lh[t+o] : '0;
    ec = ein ? lcl[t+o] : '0;
    req_offset = OW'(o); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R10 rsp_valid"}, 64'(rsp_valid), 1);
    chk(rsp_inwin == ein, {tag, " R8/R9 inwin"}, 64'(rsp_inwin), 64'(ein));
    chk(rsp_hit == eh && rsp_clus == ec, {tag, " R8/R9 data"},
        {32'(rsp_hit), 32'(rsp_clus)}, {32'(eh), 32'(ec)});
    @(negedge clk);
  endtask

  task automatic finish_post(input int t, input string tag);
    send_bg(POST - 1, '0);
    chk(st_triggered && !st_done, {tag, " R7 still post"}, 64'(st_done), 0);
    chk(!req_ready, {tag, " R10 no read while post"}, 64'(req_ready), 0);
    send(bgh(lc), 16'h0000);
    chk(st_done && !st_triggered, {tag, " R7 done after POST"}, 64'(st_done), 1);
    chk(lc - 1 - t == POST, {tag, " R7 post length"}, 64'(lc - 1 - t), POST);
  endtask

  task automatic t_reset();
    chk(!st_armed && !st_triggered && !st_done, "R1 status idle",
        {st_armed, st_triggered, st_done}, 0);
    chk(!req_ready && !rsp_valid, "R1 readout idle", {req_ready, rsp_valid}, 0);
  endtask

  task automatic t_pattern();
    int t;
    cfg_mode = 2'b00; cfg_care = 16'h000F; cfg_value = 16'h0005;
    do_arm();
    send_bg(2, '0);
    send(16'hFF05, '0);          // match too early (R6)
    send_bg(PRE - 3, '0);
    chk(st_armed && !st_triggered, "R6 early match ignored", 64'(st_triggered), 0);
    send(16'h1237, '0);          // pixel 1 wrong: no match (R2)
    send_bg(2, '0);
    chk(st_armed, "R2 near miss no fire", 64'(st_triggered), 0);
    t = lc;
    send(16'hABC5, 16'h0000);    // upper pixels don't care (R2)
    chk(st_triggered, "R2 pattern fires", 64'(st_triggered), 1);
    finish_post(t, "pat");
    send_bg(3, '0);              // after done: not recorded (R5)
    rd(0, t, "pat o0");
    rd(-PRE, t, "pat o-PRE");
    rd(-1, t, "pat o-1");
    rd(1, t, "pat o+1");
    rd(POST, t, "pat o+POST");
    rd(POST + 1, t, "pat past end");
    rd(-PRE - 1, t, "pat before start");
  endtask

  task automatic t_count();
    int t;
    cfg_mode = 2'b01; cfg_min_clusters = CW'(3);
    do_arm();
    send_bg(PRE, 16'h0003);
    send(16'h0005, 16'h0000);    // pattern match ignored in count mode (R4)
    send(bgh(lc), 16'h0300);     // two clusters: below threshold (R3)
    chk(st_armed, "R3 count below min", 64'(st_triggered), 0);
    t = lc;
    send(bgh(lc), 16'h8101);
    chk(st_triggered, "R3 count reaches min", 64'(st_triggered), 1);
    finish_post(t, "cnt");
    rd(0, t, "cnt o0");
    rd(-2, t, "cnt o-2");
  endtask

  task automatic t_and();
    int t;
    cfg_mode = 2'b10; cfg_min_clusters = CW'(2); cfg_care = 16'h000F; cfg_value = 16'h0005;
    do_arm();
    send_bg(PRE, 16'h0001);
    send(16'h0005, 16'h0001);
    send(bgh(lc), 16'h0011);
    chk(st_armed, "R4 AND needs both", 64'(st_triggered), 0);
    t = lc;
    send(16'h7005, 16'h0030);
    chk(st_triggered, "R4 AND fires", 64'(st_triggered), 1);
    finish_post(t, "and");
    rd(0, t, "and o0");
  endtask

  task automatic t_or_bp();
    int t;
    cfg_mode = 2'b11; cfg_min_clusters = CW'(4);
    do_arm();
    send_bg(PRE, 16'h0000);
    t = lc;
    send(bgh(lc), 16'hF000);     // count alone fires in OR mode
    chk(st_triggered, "R4 OR count alone", 64'(st_triggered), 1);
    finish_post(t, "or");
    rd(0, t, "or o0");
    // back-pressure (R11)
    rsp_ready = 1'b0;
    req_offset = OW'(1); req_valid = 1'b1;
    @(negedge clk);
    chk(rsp_valid && rsp_hit == lh[t+1], "R11 first rsp", 64'(rsp_hit), 64'(lh[t+1]));
    req_offset = OW'(-1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready && rsp_valid && rsp_hit == lh[t+1], "R11 stall holds",
          64'(rsp_hit), 64'(lh[t+1]));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_hit == lh[t-1], "R11 next after release",
        64'(rsp_hit), 64'(lh[t-1]));
    @(negedge clk);
    chk(!rsp_valid, "R10 rsp drains", 64'(rsp_valid), 0);
  endtask

  task automatic t_rearm();
    do_arm();
    chk(st_armed && !st_done, "R12 rearm from done", {st_armed, st_done}, 2'b10);
    chk(!req_ready, "R12 reads blocked", 64'(req_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pattern();
    t_count();
    t_and();
    t_or_bp();
    t_rearm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule